// File: doc/BRIEF.md
# Scatter-Gather Receive Descriptor Filler

This block takes one packet at a time from a ready/valid stream and lays it into memory through a linked chain of buffer descriptors. It reads a descriptor, fills that descriptor's buffer up to its capacity and writes a status word back. It then follows the descriptor's next pointer and repeats until the packet ends. A packet that is larger than one buffer is spread over as many descriptors as it needs. The first descriptor of the packet carries a start marker. The last one carries an end marker and a copy of five application words, which arrive beforehand on a separate sideband stream.

Register decoding and interrupt handling sit outside this block. Software-facing logic loads the chain start pointer with a `chainStart` pulse, holds the tail pointer on `tailAddr` and enables the channel with `runEn`. It raises `tailKick` whenever the tail moves forward. The block reports back through `halted` and `idle` and a one-cycle `pktDone` pulse, plus two sticky error flags. Memory is reached through a simple port. A read issued in one cycle returns its data on `memRdata` in the next cycle, and a write completes in the cycle it is issued.

Descriptor layout, as byte offsets from the descriptor address: next pointer at +0, buffer address at +8, control at +24, status at +28, application words at +32 to +48. The stream carries 32-bit words. Buffer capacity is a byte count, and its two low bits are ignored.

Top module: `rx_desc_filler`

## Requirements
- R1: A descriptor's capacity in bytes is control bits 22:0, counted in whole words. The block writes min(capacity, remaining packet) to consecutive buffer addresses and records that byte count in status bits 22:0.
- R2: Status bit 27 (start of frame) is set only in the first descriptor that a packet uses.
- R3: The descriptor that takes the packet's last word gets status bit 26 (end of frame). The five latched application words are written at +32..+48 of that descriptor, and `pktDone` pulses for one cycle after its status write.
- R4: Every descriptor that is used gets status bit 31 (complete). All status bits other than 31, 27, 26 and 22:0 are written as zero.
- R5: If a fetched descriptor already has status bit 31 set, the block sets `halted` and writes neither that descriptor nor its buffer. If this happens at the start of a packet, no word of the packet is accepted.
- R6: After the tail descriptor is written back, the block sets `idle` and stops. Any remaining words of the current packet are accepted and dropped, and `overflow` is set. A halt in the middle of a packet also drops the remaining words and sets `overflow`.
- R7: The sideband is accepted only as exactly five words ending with `appLast`. Any other count sets `appErr` and keeps the previous set. A valid new set replaces the old one.
- R8: `sReady` is low whenever `runEn` is low. It is also low while `idle` or `halted` is set, except while the rest of a cut-off packet is being dropped.
- R9: The block follows each descriptor's next pointer to the following descriptor. It never reads and writes memory in the same cycle.
- R10: After reset `halted` is 1 and `idle`, `overflow`, `appErr`, `pktDone` and `sReady` are 0. `chainStart` loads the start pointer and clears `halted`, `idle`, `overflow` and `appErr`. `tailKick` clears `idle`.
- R11: A descriptor with zero capacity is written back with length 0 and without end of frame. The packet continues in the next descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Channel run enable |
| chainStart | input | 1 | Load start pointer, clear status flags |
| startAddr | input | ADDR_W | First descriptor address |
| tailAddr | input | ADDR_W | Tail descriptor address |
| tailKick | input | 1 | Tail advanced, clears idle |
| appValid | input | 1 | Sideband word valid |
| appData | input | 32 | Sideband word |
| appLast | input | 1 | Last sideband word |
| sValid | input | 1 | Packet word valid |
| sData | input | 32 | Packet word |
| sLast | input | 1 | Last word of packet |
| sReady | output | 1 | Packet word accepted |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memRdata | input | 32 | Read data, one cycle after memRd |
| halted | output | 1 | Stopped on a used descriptor |
| idle | output | 1 | Stopped at the tail |
| pktDone | output | 1 | One-cycle packet-complete pulse |
| overflow | output | 1 | Packet words were dropped (sticky) |
| appErr | output | 1 | Malformed sideband (sticky) |

## Verification
A descriptor fetch takes five cycles before the first word can be accepted. Packet words are written in the cycle they are accepted. The end descriptor then needs five application writes and one status write, and `pktDone`, `idle`, `halted` and `overflow` change at the edge of that status write. The bench waits twelve cycles after the last accepted word, which covers that whole tail. It then samples outputs and its own memory model on a falling edge, so every result it compares has already settled. `sReady` depends only on state and `runEn`, so it is read at the falling edge before each handshake and during stall windows that are held for several cycles.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 23;
  localparam int APP_N   = 5;
  localparam int IDX_W   = $clog2(APP_N);
  localparam int CAP_W   = LEN_W - 2;
  localparam int BIT_DONE = 31;
  localparam int BIT_SOF  = 27;
  localparam int BIT_EOF  = 26;
  localparam int OFS_NEXT = 0;
  localparam int OFS_BUF  = 8;
  localparam int OFS_CTRL = 24;
  localparam int OFS_STAT = 28;
  localparam int OFS_APP  = 32;

  typedef enum logic [2:0] {
    SEL_NEXT, SEL_BUF, SEL_CTRL, SEL_STAT, SEL_DATA, SEL_APP
  } addrSel_e;

  typedef enum logic [3:0] {
    S_WAIT, S_RSTAT, S_RCTRL, S_RBUF, S_RNXT, S_CHECK,
    S_XFER, S_WAPP, S_WSTAT, S_DRAIN
  } state_e;

  typedef struct packed {
    logic       latchStat;
    logic       latchCtrl;
    logic       latchBuf;
    logic       latchNxt;
    logic       beat;
    logic       advance;
    addrSel_e   sel;
    logic [IDX_W-1:0] appIdx;
    logic       sofBit;
    logic       eofBit;
  } strobe_t;
endpackage

// File: rtl/rxf_app_capture.sv
module rxf_app_capture
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic appValid,
  input  logic [WORD_W-1:0] appData,
  input  logic appLast,
  output logic [APP_N-1:0][WORD_W-1:0] appWords,
  output logic appErr
);
  localparam int CNT_W = $clog2(APP_N + 1);

  logic [APP_N-1:0][WORD_W-1:0] stage;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage    <= '0;
      appWords <= '0;
      cnt      <= '0;
      appErr   <= 1'b0;
    end else begin
      if (clr) appErr <= 1'b0;
      if (appValid) begin
        if (cnt < CNT_W'(APP_N)) stage[cnt] <= appData;
        if (appLast) begin
          cnt <= '0;
          if (cnt == CNT_W'(APP_N - 1)) begin
            for (int i = 0; i < APP_N - 1; i++) appWords[i] <= stage[i];
            appWords[APP_N-1] <= appData;
          end else begin
            appErr <= 1'b1;
          end
        end else if (cnt != CNT_W'(APP_N)) begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic chainStart,
  input  logic tailKick,
  input  logic sValid,
  input  logic sLast,
  input  logic descUsed,
  input  logic capZero,
  input  logic lastSlot,
  input  logic atTail,
  output strobe_t strb,
  output logic memRd,
  output logic memWr,
  output logic sReady,
  output logic halted,
  output logic idle,
  output logic overflow,
  output logic pktDone
);
  state_e state, nxt;
  logic firstDesc, eofFlag;
  logic [IDX_W-1:0] appIdx;
  logic beat;

  assign sReady = runEn && (state == S_XFER || state == S_DRAIN);
  assign beat   = sValid && sReady;

  always_comb begin
    nxt          = state;
    memRd        = 1'b0;
    memWr        = 1'b0;
    strb         = '0;
    strb.sel     = SEL_STAT;
    strb.appIdx  = appIdx;
    strb.sofBit  = firstDesc;
    strb.eofBit  = eofFlag;
    case (state)
      S_WAIT:  if (runEn && !idle && !halted && sValid) nxt = S_RSTAT;
      S_RSTAT: begin memRd = 1'b1; strb.sel = SEL_STAT; nxt = S_RCTRL; end
      S_RCTRL: begin memRd = 1'b1; strb.sel = SEL_CTRL; strb.latchStat = 1'b1; nxt = S_RBUF; end
      S_RBUF:  begin memRd = 1'b1; strb.sel = SEL_BUF;  strb.latchCtrl = 1'b1; nxt = S_RNXT; end
      S_RNXT:  begin memRd = 1'b1; strb.sel = SEL_NEXT; strb.latchBuf  = 1'b1; nxt = S_CHECK; end
      S_CHECK: begin
        strb.latchNxt = 1'b1;
        if (descUsed)     nxt = firstDesc ? S_WAIT : S_DRAIN;
        else if (capZero) nxt = S_WSTAT;
        else              nxt = S_XFER;
      end
      S_XFER: begin
        strb.sel = SEL_DATA;
        if (beat) begin
          memWr     = 1'b1;
          strb.beat = 1'b1;
          if (sLast)         nxt = S_WAPP;
          else if (lastSlot) nxt = S_WSTAT;
        end
      end
      S_WAPP: begin
        memWr    = 1'b1;
        strb.sel = SEL_APP;
        if (appIdx == IDX_W'(APP_N - 1)) nxt = S_WSTAT;
      end
      S_WSTAT: begin
        memWr        = 1'b1;
        strb.sel     = SEL_STAT;
        strb.advance = 1'b1;
        if (eofFlag)     nxt = S_WAIT;
        else if (atTail) nxt = S_DRAIN;
        else             nxt = S_RSTAT;
      end
      S_DRAIN: if (beat && sLast) nxt = S_WAIT;
      default: nxt = S_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_WAIT;
      halted    <= 1'b1;
      idle      <= 1'b0;
      overflow  <= 1'b0;
      pktDone   <= 1'b0;
      firstDesc <= 1'b0;
      eofFlag   <= 1'b0;
      appIdx    <= '0;
    end else begin
      state   <= nxt;
      pktDone <= 1'b0;
      if (chainStart) begin
        halted   <= 1'b0;
        idle     <= 1'b0;
        overflow <= 1'b0;
      end
      if (tailKick) idle <= 1'b0;
      case (state)
        S_WAIT: if (nxt == S_RSTAT) begin
          firstDesc <= 1'b1;
          eofFlag   <= 1'b0;
        end
        S_CHECK: if (descUsed) begin
          halted <= 1'b1;
          if (!firstDesc) overflow <= 1'b1;
        end
        S_XFER: if (beat && sLast) begin
          eofFlag <= 1'b1;
          appIdx  <= '0;
        end
        S_WAPP: appIdx <= appIdx + 1'b1;
        S_WSTAT: begin
          if (atTail) idle <= 1'b1;
          if (eofFlag) pktDone <= 1'b1;
          else begin
            firstDesc <= 1'b0;
            if (atTail) overflow <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic chainStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] tailAddr,
  input  strobe_t strb,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] sData,
  input  logic [APP_N-1:0][WORD_W-1:0] appWords,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic descUsed,
  output logic capZero,
  output logic lastSlot,
  output logic atTail
);
  logic [ADDR_W-1:0] curPtr, nxtPtr, bufPtr;
  logic [CAP_W-1:0]  capWords, wordCnt;
  logic [WORD_W-1:0] statWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr   <= '0;
      nxtPtr   <= '0;
      bufPtr   <= '0;
      capWords <= '0;
      wordCnt  <= '0;
      descUsed <= 1'b0;
    end else begin
      if (chainStart)     curPtr   <= startAddr;
      if (strb.latchStat) descUsed <= memRdata[BIT_DONE];
      if (strb.latchCtrl) capWords <= memRdata[LEN_W-1:2];
      if (strb.latchBuf) begin
        bufPtr  <= memRdata[ADDR_W-1:0];
        wordCnt <= '0;
      end
      if (strb.latchNxt)  nxtPtr <= memRdata[ADDR_W-1:0];
      if (strb.beat) begin
        bufPtr  <= bufPtr + ADDR_W'(4);
        wordCnt <= wordCnt + 1'b1;
      end
      if (strb.advance)   curPtr <= nxtPtr;
    end
  end

  assign capZero  = (capWords == '0);
  assign lastSlot = (wordCnt + 1'b1 == capWords);
  assign atTail   = (curPtr == tailAddr);

  always_comb begin
    statWord                = '0;
    statWord[BIT_DONE]      = 1'b1;
    statWord[BIT_SOF]       = strb.sofBit;
    statWord[BIT_EOF]       = strb.eofBit;
    statWord[LEN_W-1:0]     = {wordCnt, 2'b00};
  end

  always_comb begin
    case (strb.sel)
      SEL_NEXT: memAddr = curPtr + ADDR_W'(OFS_NEXT);
      SEL_BUF:  memAddr = curPtr + ADDR_W'(OFS_BUF);
      SEL_CTRL: memAddr = curPtr + ADDR_W'(OFS_CTRL);
      SEL_DATA: memAddr = bufPtr;
      SEL_APP:  memAddr = curPtr + ADDR_W'(OFS_APP) + ADDR_W'({strb.appIdx, 2'b00});
      default:  memAddr = curPtr + ADDR_W'(OFS_STAT);
    endcase
    case (strb.sel)
      SEL_DATA: memWdata = sData;
      SEL_APP:  memWdata = appWords[strb.appIdx];
      default:  memWdata = statWord;
    endcase
  end
endmodule

// File: rtl/rx_desc_filler.sv
module rx_desc_filler
  import rxf_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic runEn,
  input  logic chainStart,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] tailAddr,
  input  logic tailKick,
  input  logic appValid,
  input  logic [31:0] appData,
  input  logic appLast,
  input  logic sValid,
  input  logic [31:0] sData,
  input  logic sLast,
  output logic sReady,
  output logic memRd,
  output logic memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0] memWdata,
  input  logic [31:0] memRdata,
  output logic halted,
  output logic idle,
  output logic pktDone,
  output logic overflow,
  output logic appErr
);
  strobe_t strb;
  logic descUsed, capZero, lastSlot, atTail;
  logic [APP_N-1:0][WORD_W-1:0] appWords;

  rxf_app_capture u_app (
    .clk(clk), .rstN(rstN), .clr(chainStart),
    .appValid(appValid), .appData(appData), .appLast(appLast),
    .appWords(appWords), .appErr(appErr)
  );

  rxf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .chainStart(chainStart),
    .tailKick(tailKick), .sValid(sValid), .sLast(sLast),
    .descUsed(descUsed), .capZero(capZero), .lastSlot(lastSlot), .atTail(atTail),
    .strb(strb), .memRd(memRd), .memWr(memWr), .sReady(sReady),
    .halted(halted), .idle(idle), .overflow(overflow), .pktDone(pktDone)
  );

  rxf_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .chainStart(chainStart),
    .startAddr(startAddr), .tailAddr(tailAddr), .strb(strb),
    .memRdata(memRdata), .sData(sData), .appWords(appWords),
    .memAddr(memAddr), .memWdata(memWdata),
    .descUsed(descUsed), .capZero(capZero), .lastSlot(lastSlot), .atTail(atTail)
  );
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic clk,
  input logic rstN,
  input logic runEn,
  input logic sReady,
  input logic memRd,
  input logic memWr,
  input logic eofWrite,
  input logic pktDone,
  input logic idle
);
  assert_ready_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    sReady |-> runEn);

  assert_mem_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |=> !pktDone);

  assert_done_after_eof_R3: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> $past(eofWrite));

  assert_idle_on_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idle) |-> $past(memWr));
endmodule

bind rx_desc_filler rxf_checker u_rxf_checker (
  .clk(clk), .rstN(rstN), .runEn(runEn), .sReady(sReady),
  .memRd(memRd), .memWr(memWr),
  .eofWrite(memWr && memWdata[31] && memWdata[26]),
  .pktDone(pktDone), .idle(idle)
);

// File: tb/test_rx_desc_filler.sv
module test_rx_desc_filler;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, runEn, chainStart, tailKick, appValid, appLast, sValid, sLast;
  logic [31:0] startAddr, tailAddr, appData, sData, memAddr, memWdata, memRdata;
  logic sReady, memRd, memWr, halted, idle, pktDone, overflow, appErr;

  rx_desc_filler i_rx_desc_filler (.*);

  logic [31:0] mem [256];
  always @(posedge clk) begin
    if (memWr) mem[memAddr[9:2]] <= memWdata;
    if (memRd) memRdata <= mem[memAddr[9:2]];
  end

  int doneCnt = 0;
  always @(posedge clk) if (rstN && pktDone) doneCnt++;

  int nChk = 0, nBad = 0;
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // columns: cap0, cap1, cap2 (bytes), packet words, descriptors used, overflow
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{32, 32, 32,  5, 1, 0},
    '{ 8, 16, 64,  7, 3, 0},
    '{ 8,  8,  8, 10, 3, 1},
    '{12, 20,  8,  3, 1, 0},
    '{ 0, 16, 16,  2, 2, 0},
    '{ 8,  8,  8,  6, 3, 0}
  };

  task automatic buildChain(int c0, int c1, int c2, logic [2:0] usedMask);
    int caps [3];
    caps = '{c0, c1, c2};
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int d = 0; d < 3; d++) begin
      mem[d*16 + 0] = (d + 1) * 64;
      mem[d*16 + 2] = 32'h200 + d * 32'h80;
      mem[d*16 + 6] = caps[d];
      mem[d*16 + 7] = usedMask[d] ? 32'h8000_0000 : 32'h0;
    end
  endtask

  task automatic startChain();
    @(negedge clk) chainStart = 1'b1;
    @(negedge clk) chainStart = 1'b0;
  endtask

  task automatic sendApp(int n, logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      appValid = 1'b1; appData = seed + i; appLast = (i == n - 1);
    end
    @(negedge clk) begin appValid = 1'b0; appLast = 1'b0; end
  endtask

  task automatic sendPkt(int n, logic [31:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sValid = 1'b1; sData = seed + i; sLast = (i == n - 1);
      while (!sReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk) begin sValid = 1'b0; sLast = 1'b0; end
  endtask

  task automatic checkChain(int caps [3], int words, int used, logic [31:0] seed,
                            logic [31:0] appSeed);
    int rem, pos, take;
    logic [31:0] exp;
    rem = words; pos = 0;
    for (int d = 0; d < used; d++) begin
      take = (caps[d] / 4 < rem) ? caps[d] / 4 : rem;
      exp = 32'h8000_0000 | (take * 4);
      if (d == 0) exp |= 32'h0800_0000;
      if (take == rem && take > 0) exp |= 32'h0400_0000;
      check($sformatf("R1 R2 R4 R11 status d%0d", d), mem[d*16 + 7], exp);
      for (int j = 0; j < take; j++)
        check($sformatf("R1 R9 data d%0d w%0d", d, j), mem[128 + d*32 + j], seed + pos + j);
      if (take == rem && take > 0)
        for (int a = 0; a < 5; a++)
          check($sformatf("R3 app d%0d a%0d", d, a), mem[d*16 + 8 + a], appSeed + a);
      rem -= take; pos += take;
    end
  endtask

  initial begin
    #2_000_000;
    nBad++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int caps [3];
    int d0;
    rstN = 0; runEn = 0; chainStart = 0; tailKick = 0; appValid = 0; appLast = 0;
    sValid = 0; sLast = 0; appData = 0; sData = 0;
    startAddr = 32'h0; tailAddr = 32'h80;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 halted", halted, 1); check("R10 idle", idle, 0);
    check("R10 overflow", overflow, 0); check("R10 appErr", appErr, 0);
    check("R10 pktDone", pktDone, 0); check("R8 sReady reset", sReady, 0);

    runEn = 1;
    for (int k = 0; k < NV; k++) begin
      caps = '{VEC[k][0], VEC[k][1], VEC[k][2]};
      buildChain(caps[0], caps[1], caps[2], 3'b000);
      startChain();
      sendApp(5, 32'hA000_0000 + k * 16);
      d0 = doneCnt;
      sendPkt(VEC[k][3], k << 16);
      repeat (12) @(negedge clk);
      checkChain(caps, VEC[k][3], VEC[k][4], k << 16, 32'hA000_0000 + k * 16);
      check($sformatf("R6 idle v%0d", k), idle, VEC[k][4] == 3);
      check($sformatf("R6 overflow v%0d", k), overflow, VEC[k][5]);
      check($sformatf("R3 pktDone v%0d", k), doneCnt - d0, VEC[k][5] == 0);
      check($sformatf("R5 halted v%0d", k), halted, 0);
    end

    // R8: idle keeps ready low; R10 tailKick clears idle
    sValid = 1; sData = 32'h55; sLast = 1;
    repeat (6) begin @(negedge clk); check("R8 ready while idle", sReady, 0); end
    sValid = 0; sLast = 0;
    @(negedge clk) tailKick = 1;
    @(negedge clk) tailKick = 0;
    check("R10 tailKick clears idle", idle, 0);

    // R8: runEn low blocks acceptance
    buildChain(32, 32, 32, 3'b000);
    runEn = 0;
    startChain();
    sValid = 1; sData = 32'h77; sLast = 1;
    repeat (6) begin @(negedge clk); check("R8 ready with runEn low", sReady, 0); end
    check("R8 no buffer write", mem[128], 0);
    sValid = 0; sLast = 0;
    runEn = 1;
    sendPkt(3, 32'h300);
    repeat (12) @(negedge clk);
    check("R1 after run", mem[7], 32'h8C00_000C);

    // R5: used descriptor at packet start
    buildChain(32, 32, 32, 3'b001);
    startChain();
    sValid = 1; sData = 32'h99; sLast = 1;
    repeat (20) @(negedge clk);
    check("R5 halted at start", halted, 1);
    check("R5 ready low", sReady, 0);
    check("R5 status untouched", mem[7], 32'h8000_0000);
    check("R5 buffer untouched", mem[128], 0);
    sValid = 0; sLast = 0;

    // R5 R6: halt mid-packet drops the rest
    buildChain(8, 8, 8, 3'b010);
    startChain();
    sendPkt(5, 32'h400);
    repeat (12) @(negedge clk);
    check("R5 halted mid", halted, 1);
    check("R6 overflow on halt", overflow, 1);
    check("R2 first status", mem[7], 32'h8800_0008);
    check("R5 d1 untouched", mem[16 + 7], 32'h8000_0000);
    check("R5 d1 buf untouched", mem[160], 0);
    check("R6 idle not set", idle, 0);

    // R7: short sideband is flagged, old set kept
    buildChain(32, 32, 32, 3'b000);
    startChain();
    sendApp(5, 32'hD000_0000);
    sendApp(3, 32'hE000_0000);
    check("R7 appErr", appErr, 1);
    sendPkt(2, 32'h500);
    repeat (12) @(negedge clk);
    for (int a = 0; a < 5; a++) check("R7 kept app", mem[8 + a], 32'hD000_0000 + a);
    buildChain(32, 32, 32, 3'b000);
    startChain();
    check("R10 appErr cleared", appErr, 0);
    sendApp(5, 32'hF000_0000);
    sendPkt(1, 32'h600);
    repeat (12) @(negedge clk);
    for (int a = 0; a < 5; a++) check("R7 overwrite app", mem[8 + a], 32'hF000_0000 + a);
    check("R3 R4 single word", mem[7], 32'h8C00_0004);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule